// File: doc/BRIEF.md
# Ethernet receive destination address filter

This block decides, for each received Ethernet frame, whether the frame is kept. It looks only at the 48-bit destination address. The address arrives one byte per cycle, the first byte marked by a start flag. While the bytes stream in, the block runs a reflected CRC-32 over them, one byte per cycle. It also keeps a copy of the address.

Two cycles after the sixth byte, the block issues a one-cycle verdict. Four mode bits set the policy:

- promiscuous: accept every frame.
- pass-all-group: accept every group-addressed frame.
- hash-group: accept a group-addressed frame only if its bin bit is set in a hash table of 64, 128 or 256 bins.
- receive-all: pass every frame but still report the real filter result.

Unicast frames are accepted only when they match one of a small bank of exact-match address entries, each with its own enable. The mode bits, the hash words and the address entries are loaded through a simple write port.

Top module: `rx_da_filter`

## Requirements
- R1: For a group address in hash-group mode, the bin index is formed as follows:
  - Run a reflected CRC-32 (polynomial 0xEDB88320, preset all ones) over the six address bytes, in arrival order and least significant bit first.
  - Complement the result and bit-reverse it.
  - Keep the top HASH_BITS bits.

  The frame is accepted exactly when that bin's bit is 1.
- R2: The bin index selects a hash word and a bit within it:
  - Index bits above bit 4 select the hash word, written at config address 8+w.
  - Index bits 4:0 select the bit within that word.
  - The table holds 2^(HASH_BITS-5) words.
- R3: With promiscuous mode on (mode register, address 0, bit 0), every frame is accepted, whatever the other settings are.
- R4: With pass-all-group mode on (mode bit 1), every frame whose first address byte has bit 0 set is accepted, whatever the hash table holds. An unmatched unicast frame is still rejected.
- R5: A group address that is not broadcast is rejected in either of two cases:
  - neither pass-all-group nor hash-group (mode bit 2) is on;
  - hash-group is on and its bin bit is 0.
- R6: The broadcast address FF:FF:FF:FF:FF:FF is always accepted.
- R7: A unicast frame is accepted when its address equals an enabled exact-match entry. Entry k is written as follows:
  - Address bytes 0..3 go at config address 16+2k, with byte 0 (the first received) in bits 7:0.
  - Bytes 4..5 go in bits 15:0 at config address 17+2k.
  - The enable is bit 31 of that second word.

  A disabled entry never matches. Entry 0 is the station's own address.
- R8: A unicast frame that matches no enabled entry is rejected, and the hash table plays no part for unicast frames.
- R9: With receive-all mode on (mode bit 3), frame_pass is 1 on every verdict while filter_hit still shows the real filter result. With receive-all off, frame_pass equals filter_hit.
- R10: The verdict has fixed timing:
  - verdict_valid is a one-cycle pulse two clock edges after the edge that takes the sixth address byte.
  - filter_hit and frame_pass are 0 whenever verdict_valid is 0.
  - Bytes that arrive without a start flag while no frame is in progress, and bytes after the sixth, are ignored and produce no verdict.
- R11: After reset, all mode bits, hash words and entry enables are 0 and all outputs are 0, so a unicast frame is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| da_valid | input | 1 | An address byte is present |
| da_first | input | 1 | This byte is the first of a destination address |
| da_byte | input | 8 | Address byte, first received byte first |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| filter_hit | output | 1 | Result of the address filter |
| frame_pass | output | 1 | Frame is to be kept (filter result or receive-all) |

## Verification
Group addresses are tried against three table states:
- an empty table, which shows the hash bit is really consulted;
- a table holding only the computed bin, which shows the index is right;
- a table holding every bin except that one, which catches any index that is off by a bit or points at the wrong word.

Unicast frames are sent that match an enabled entry, that differ in one byte, and that match a disabled entry; together these separate exact matching from enable handling. The same unmatched and group frames are then replayed under each mode bit. This shows how promiscuous, pass-all-group and receive-all change the outcome, and that broadcast overrides every setting. The timing of each verdict is sampled at every cycle around its expected slot, and stray bytes with no start flag are fed to confirm that they produce no verdict.

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
  parameter int HASH_BITS = 6,
  parameter int NUM_ADDR  = 4,
  parameter int CFG_AW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              da_valid,
  input  logic              da_first,
  input  logic [7:0]        da_byte,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              verdict_valid,
  output logic              filter_hit,
  output logic              frame_pass
);

  localparam int          WSEL_W     = HASH_BITS - 5;
  localparam int          HASH_WORDS = 1 << WSEL_W;
  localparam int          HASH_BASE  = 8;
  localparam int          ADDR_BASE  = 16;
  localparam logic [31:0] POLY       = 32'hEDB88320;

  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'd0, b};
    for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
    return c;
  endfunction

  // configuration state
  logic m_promisc, m_all_grp, m_hash_grp, m_rx_all;
  logic [31:0]         hash_tbl [HASH_WORDS];
  logic [47:0]         ent_addr [NUM_ADDR];
  logic [NUM_ADDR-1:0] ent_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_rx_all, m_hash_grp, m_all_grp, m_promisc} <= '0;
      for (int w = 0; w < HASH_WORDS; w++) hash_tbl[w] <= '0;
      for (int k = 0; k < NUM_ADDR; k++) ent_addr[k] <= '0;
      ent_en <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == '0) {m_rx_all, m_hash_grp, m_all_grp, m_promisc} <= cfg_wdata[3:0];
      for (int w = 0; w < HASH_WORDS; w++)
        if (cfg_addr == CFG_AW'(HASH_BASE + w)) hash_tbl[w] <= cfg_wdata;
      for (int k = 0; k < NUM_ADDR; k++) begin
        if (cfg_addr == CFG_AW'(ADDR_BASE + 2*k)) ent_addr[k][31:0] <= cfg_wdata;
        if (cfg_addr == CFG_AW'(ADDR_BASE + 2*k + 1)) begin
          ent_addr[k][47:32] <= cfg_wdata[15:0];
          ent_en[k]          <= cfg_wdata[31];
        end
      end
    end
  end

  // byte capture and running CRC
  logic [2:0]  cnt;
  logic [47:0] da;
  logic [31:0] crc;
  logic        fire;
  logic [2:0]  pos;
  logic        take;

  assign pos  = da_first ? 3'd0 : cnt;
  assign take = da_valid && (da_first || (cnt != 3'd0 && cnt != 3'd6));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      da   <= '0;
      crc  <= '1;
      fire <= 1'b0;
    end else begin
      fire <= take && (pos == 3'd5);
      if (take) begin
        cnt                 <= pos + 3'd1;
        da[{pos, 3'b0} +: 8] <= da_byte;
        crc                 <= crc_step(da_first ? 32'hFFFF_FFFF : crc, da_byte);
      end
    end
  end

  // lookup stage
  logic [HASH_BITS-1:0] hidx;
  logic [NUM_ADDR-1:0]  ent_match;

  always_comb
    for (int j = 0; j < HASH_BITS; j++) hidx[HASH_BITS-1-j] = ~crc[j];

  for (genvar k = 0; k < NUM_ADDR; k++) begin : g_ent
    assign ent_match[k] = ent_en[k] && (ent_addr[k] == da);
  end

  logic s1_v, s1_grp, s1_bcast, s1_hash, s1_uc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1_v, s1_grp, s1_bcast, s1_hash, s1_uc} <= '0;
    end else begin
      s1_v     <= fire;
      s1_grp   <= da[0];
      s1_bcast <= &da;
      s1_hash  <= hash_tbl[hidx[HASH_BITS-1 -: WSEL_W]][hidx[4:0]];
      s1_uc    <= |ent_match;
    end
  end

  // verdict stage
  logic hit;
  assign hit = m_promisc || s1_bcast ||
               (s1_grp ? (m_all_grp || (m_hash_grp && s1_hash)) : s1_uc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_valid <= 1'b0;
      filter_hit    <= 1'b0;
      frame_pass    <= 1'b0;
    end else begin
      verdict_valid <= s1_v;
      filter_hit    <= s1_v && hit;
      frame_pass    <= s1_v && (hit || m_rx_all);
    end
  end

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ##2 verdict_valid);
  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !verdict_valid);
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> (!filter_hit && !frame_pass));
  p_promisc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && m_promisc) |=> filter_hit);
  p_bcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_bcast) |=> filter_hit);
  p_rx_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && m_rx_all) |=> frame_pass);
  p_pass_eq_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && !m_rx_all && !$past(cfg_we)) |-> (frame_pass == filter_hit));

endmodule

// File: tb/rx_da_filter_tb.sv
module rx_da_filter_tb;
  localparam int HB = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic da_valid = 1'b0, da_first = 1'b0;
  logic [7:0] da_byte = '0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic verdict_valid, filter_hit, frame_pass;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_da_filter #(.HASH_BITS(HB), .NUM_ADDR(4), .CFG_AW(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_first(da_first), .da_byte(da_byte),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .verdict_valid(verdict_valid), .filter_hit(filter_hit), .frame_pass(frame_pass));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mode(input bit promisc, input bit all_grp, input bit hash_grp, input bit rx_all);
    cfg_write(0, {28'd0, rx_all, hash_grp, all_grp, promisc});
  endtask

  task automatic set_entry(input int k, input logic [47:0] a, input bit en);
    cfg_write(16 + 2*k, a[31:0]);
    cfg_write(17 + 2*k, {en, 15'd0, a[47:32]});
  endtask

  function automatic int bin_of(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] nc;
    int idx = 0;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[0] ^ a[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    nc = ~c;
    for (int j = 0; j < HB; j++) if (nc[j]) idx = idx | (1 << (HB-1-j));
    return idx;
  endfunction

  task automatic send(input logic [47:0] a, input bit exp_hit, input bit exp_pass, input string tag);
    for (int i = 0; i < 6; i++) begin
      da_valid = 1'b1; da_first = (i == 0); da_byte = a[8*i +: 8];
      @(negedge clk);
    end
    da_valid = 1'b0; da_first = 1'b0;
    chk({tag, " R10 valid k"}, verdict_valid, 0);
    @(negedge clk);
    chk({tag, " R10 valid k+1"}, verdict_valid, 0);
    @(negedge clk);
    chk({tag, " R10 valid k+2"}, verdict_valid, 1);
    chk({tag, " hit"}, filter_hit, exp_hit);
    chk({tag, " pass"}, frame_pass, exp_pass);
    @(negedge clk);
    chk({tag, " R10 pulse end"}, {verdict_valid, filter_hit, frame_pass}, 0);
  endtask

  localparam logic [47:0] UA = 48'h66_55_44_33_22_10;
  localparam logic [47:0] UB = 48'h0A_0B_0C_0D_0E_02;
  localparam logic [47:0] GM = 48'hFB_00_00_5E_00_01;
  localparam logic [47:0] GN = 48'h34_12_CC_80_00_33;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

  task automatic t_reset;
    chk("R11 outputs after reset", {verdict_valid, filter_hit, frame_pass}, 0);
    send(UA, 0, 0, "R11 unicast after reset");
    send(GM, 0, 0, "R5 group with no mode");
  endtask

  task automatic t_unicast;
    set_entry(0, UA, 1);
    send(UA, 1, 1, "R7 station entry match");
    send(UA ^ 48'h01_00_00_00_00_00, 0, 0, "R8 one byte differs");
    set_entry(2, UB, 0);
    send(UB, 0, 0, "R7 disabled entry");
    set_entry(2, UB, 1);
    send(UB, 1, 1, "R7 enabled entry 2");
    cfg_write(8, 32'hFFFF_FFFF); cfg_write(9, 32'hFFFF_FFFF);
    set_mode(0, 0, 1, 0);
    send(48'h00_00_00_00_00_04, 0, 0, "R8 unicast ignores hash");
    cfg_write(8, 0); cfg_write(9, 0);
  endtask

  task automatic t_hash(input logic [47:0] g, input string nm);
    int b = bin_of(g);
    int w = b >> 5;
    logic [31:0] m = 32'd1 << (b & 31);
    set_mode(0, 0, 1, 0);
    cfg_write(8, 0); cfg_write(9, 0);
    send(g, 0, 0, {"R5 empty table ", nm});
    cfg_write(8 + w, m);
    send(g, 1, 1, {"R1 own bin set ", nm});
    cfg_write(8 + w, ~m); cfg_write(8 + (1 - w), 32'hFFFF_FFFF);
    send(g, 0, 0, {"R2 all but own bin ", nm});
    cfg_write(8, 0); cfg_write(9, 0);
  endtask

  task automatic t_pass_all;
    set_mode(0, 1, 0, 0);
    send(GM, 1, 1, "R4 group pass all");
    send(GN, 1, 1, "R4 second group pass all");
    send(48'h00_00_00_00_00_08, 0, 0, "R4 unicast unmatched");
  endtask

  task automatic t_bcast;
    set_mode(0, 0, 0, 0);
    send(BC, 1, 1, "R6 broadcast no mode");
    set_mode(0, 0, 1, 0);
    send(BC, 1, 1, "R6 broadcast empty hash");
  endtask

  task automatic t_promisc;
    set_mode(1, 0, 0, 0);
    send(48'h00_00_00_00_00_08, 1, 1, "R3 unicast promisc");
    send(GM, 1, 1, "R3 group promisc");
  endtask

  task automatic t_rx_all;
    set_mode(0, 0, 0, 1);
    send(48'h00_00_00_00_00_08, 0, 1, "R9 unmatched rx all");
    send(UA, 1, 1, "R9 matched rx all");
    set_mode(0, 0, 0, 0);
    send(48'h00_00_00_00_00_08, 0, 0, "R9 rx all off");
  endtask

  task automatic t_stray;
    bit seen = 1'b0;
    set_mode(1, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      da_valid = 1'b1; da_first = 1'b0; da_byte = 8'(i);
      @(negedge clk);
      seen |= verdict_valid;
    end
    da_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      seen |= verdict_valid;
    end
    chk("R10 stray bytes ignored", seen, 0);
    set_mode(0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_hash(GM, "GM");
    t_hash(GN, "GN");
    t_pass_all();
    t_bcast();
    t_promisc();
    t_rx_all();
    t_stray();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule